// File: doc/BRIEF.md
# ADC Power-Up Sequencer

This block drives the three analog power enables of an on-chip analog-to-digital converter: bandgap, reference buffer and converter core. It also drives the clock enable of the converter. It counts out the settling times the analog blocks need, raises a ready flag only once conversions are safe, and passes conversion-start requests through only while that flag is high. A power-up request starts a sequence, and a mode input chooses its style. In staged mode the bandgap and reference come up first, then the core follows after the bandgap settling time, and ready follows after the core settling time. In all-at-once mode the three enables rise together and ready follows after the bandgap settling time alone.

A power-down request takes the converter to one of three low-power configurations, picked by a two-bit select: standby, deep standby or off. The core always goes off before the bandgap and reference. Leaving standby runs only the core settling wait, because the bandgap stayed up. All delays are given in microseconds and turned into clock counts from a clock-frequency parameter.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it, all enables, `aclk_en`, `ready` and `conv_start` are low, and the block sits in the off configuration.
- R2: In staged mode (`simul_sel`=0 at the request), `bg_en` and `ref_en` rise in the cycle after a power-up request is sampled. `core_en` rises exactly BG cycles after that, and `ready` rises exactly CORE cycles after `core_en`. BG = max(1, (CLK_HZ/1e6)·BG_SETTLE_US), and CORE is computed the same way from CORE_SETTLE_US.
- R3: In all-at-once mode (`simul_sel`=1 at the request), all three enables rise in the same cycle, and `ready` rises exactly BG cycles later.
- R4: `core_en` is never high unless `bg_en` and `ref_en` are both high.
- R5: `conv_start` equals `conv_req` only while `ready` is high and `pwr_dn_req` is low. Otherwise it is low.
- R6: A power-down request clears `ready` and `core_en` in the next cycle. If the core was on, `bg_en`/`ref_en` stay high for that one cycle and then follow the target configuration.
- R7: `lp_sel` picks the power-down target. 2'b01 is standby: clock, bandgap and reference on, core off. 2'b10 is deep standby: clock on, analog blocks off. 2'b00 and 2'b11 are off: everything low. Standby is only entered if the bandgap had finished settling; otherwise 2'b01 gives deep standby.
- R8: A power-up request in standby raises `core_en` in the next cycle, with `bg_en` staying high, and raises `ready` exactly CORE cycles later.
- R9: A power-up request is ignored while a sequence is running or while ready. A power-down request in the same cycle as a power-up request wins.
- R10: `aclk_en` is high in every configuration except off, and whenever any analog enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_up_req | input | 1 | Power-up request, sampled each cycle |
| pwr_dn_req | input | 1 | Power-down request, sampled each cycle |
| simul_sel | input | 1 | 1 = all-at-once sequence, 0 = staged sequence |
| lp_sel | input | 2 | Power-down target: 01 standby, 10 deep standby, 00/11 off |
| conv_req | input | 1 | Conversion-start request |
| aclk_en | output | 1 | Converter clock enable |
| bg_en | output | 1 | Bandgap enable |
| ref_en | output | 1 | Reference enable |
| core_en | output | 1 | Converter core enable |
| ready | output | 1 | Conversions may start |
| conv_start | output | 1 | Gated conversion start |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, BG_SETTLE_US = 40 and CORE_SETTLE_US = 12. This gives a bandgap wait of 40 cycles and a core wait of 12 cycles, so every settling edge can be sampled one cycle early and exactly on time within a short run. With these short waits the bench can afford both sequence styles, every power-down target, the standby resume, a repeated request in mid-sequence and a reset in mid-sequence in a single pass. The real defaults, 750000 and 150000 cycles, differ only in counter width.

// File: rtl/adc_pwr_pkg.sv
// Shared types and helpers for the converter power sequencer.
// Assumes settling times are given in whole microseconds.
package adc_pwr_pkg;

    // Sequencer states; outputs are decoded from these.
    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_DEEP      = 3'd1,
        ST_STANDBY   = 3'd2,
        ST_BG_WAIT   = 3'd3,
        ST_CORE_WAIT = 3'd4,
        ST_READY     = 3'd5,
        ST_SHED      = 3'd6
    } pwr_state_e;

    // Power-down target encoding on lp_sel.
    typedef enum logic [1:0] {
        LP_OFF     = 2'b00,
        LP_STANDBY = 2'b01,
        LP_DEEP    = 2'b10,
        LP_OFF_ALT = 2'b11
    } lp_sel_e;

    // Decoded analog controls.
    typedef struct packed {
        logic aclk;
        logic bg;
        logic refb;
        logic core;
        logic rdy;
    } pwr_out_t;

    // Clock cycles for a settling time; never less than one.
    function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                  input int unsigned us);
        int unsigned per_us;
        int unsigned cyc;
        per_us = clk_hz / 32'd1_000_000;
        cyc    = per_us * us;
        return (cyc == 0) ? 32'd1 : cyc;
    endfunction

endpackage

// File: rtl/adc_pwr_timer.sv
// Settling down-counter shared by both waits.
// Loaded with a count N; 'last' is high in the cycle whose closing edge
// ends an N-cycle window that began at the loading edge.
// Assumes load values are at least 1.
module adc_pwr_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final cycle of the window.
    always_comb begin
        last = (cnt_q == CNT_W'(1));
    end

    // R2: an idle counter stays idle until reloaded
    p_timer_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

    // R2: the final-cycle flag lasts one cycle per window
    p_last_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !last);

endmodule

// File: rtl/adc_pwr_fsm.sv
// Sequencing state machine for the converter power controls.
// Handles staged and all-at-once power-up, standby resume, and
// power-down to a selectable target with core-first shedding.
// Assumes request inputs are synchronous to clk.
module adc_pwr_fsm
    import adc_pwr_pkg::*;
#(
    parameter int unsigned BG_CYC   = 40,
    parameter int unsigned CORE_CYC = 12,
    parameter int          CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_up_req,
    input  logic             pwr_dn_req,
    input  logic             simul_sel,
    input  logic [1:0]       lp_sel,
    input  logic             tmr_last,
    output pwr_state_e       state,
    output logic             simul_q,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] BG_V   = CNT_W'(BG_CYC);
    localparam logic [CNT_W-1:0] CORE_V = CNT_W'(CORE_CYC);

    pwr_state_e st_q, st_n, tgt_q, tgt_n, tgt_c;
    logic       simul_n;
    logic       core_on;
    logic       bg_settled;

    // Whether the core is powered, and whether the bandgap has settled.
    always_comb begin
        core_on    = (st_q == ST_CORE_WAIT) || (st_q == ST_READY) ||
                     ((st_q == ST_BG_WAIT) && simul_q);
        bg_settled = (st_q == ST_CORE_WAIT) || (st_q == ST_READY) ||
                     (st_q == ST_STANDBY);
    end

    // Power-down target from lp_sel, demoting standby if unsettled.
    always_comb begin
        case (lp_sel_e'(lp_sel))
            LP_STANDBY: tgt_c = bg_settled ? ST_STANDBY : ST_DEEP;
            LP_DEEP:    tgt_c = ST_DEEP;
            default:    tgt_c = ST_OFF;
        endcase
    end

    // Next state, timer loads and latched sequencing mode.
    always_comb begin
        st_n     = st_q;
        tgt_n    = tgt_q;
        simul_n  = simul_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (pwr_dn_req && st_q != ST_SHED) begin
            if (core_on) begin
                st_n  = ST_SHED;
                tgt_n = tgt_c;
            end else begin
                st_n = tgt_c;
            end
        end else begin
            case (st_q)
                ST_OFF, ST_DEEP: begin
                    if (pwr_up_req) begin
                        st_n     = ST_BG_WAIT;
                        simul_n  = simul_sel;
                        tmr_load = 1'b1;
                        tmr_val  = BG_V;
                    end
                end
                ST_STANDBY: begin
                    if (pwr_up_req) begin
                        st_n     = ST_CORE_WAIT;
                        simul_n  = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = CORE_V;
                    end
                end
                ST_BG_WAIT: begin
                    if (tmr_last) begin
                        if (simul_q) begin
                            st_n = ST_READY;
                        end else begin
                            st_n     = ST_CORE_WAIT;
                            tmr_load = 1'b1;
                            tmr_val  = CORE_V;
                        end
                    end
                end
                ST_CORE_WAIT: begin
                    if (tmr_last) begin
                        st_n = ST_READY;
                    end
                end
                ST_SHED: begin
                    st_n = tgt_q;
                end
                default: begin
                    st_n = st_q;
                end
            endcase
        end
    end

    // State, shedding target and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_OFF;
            tgt_q   <= ST_OFF;
            simul_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            tgt_q   <= tgt_n;
            simul_q <= simul_n;
        end
    end

    // Export the state to the decoder.
    always_comb begin
        state = st_q;
    end

    // R6: a power-down request always leaves the ready state
    p_dn_leaves_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_req |=> (st_q != ST_READY));

    // R9: ready persists until a power-down request
    p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && !pwr_dn_req) |=> (st_q == ST_READY));

    // R6: shedding lasts exactly one cycle
    p_shed_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHED) |=> (st_q != ST_SHED));

endmodule

// File: rtl/adc_pwr_outdec.sv
// Decodes the sequencer state into the analog controls.
// Assumes the state comes from a register, so the outputs are glitch-free.
module adc_pwr_outdec
    import adc_pwr_pkg::*;
(
    input  pwr_state_e state,
    input  logic       simul_q,
    output pwr_out_t   ctl
);

    // Per-state analog control pattern.
    always_comb begin
        ctl = '0;
        case (state)
            ST_OFF: begin
                ctl = '0;
            end
            ST_DEEP: begin
                ctl.aclk = 1'b1;
            end
            ST_STANDBY, ST_SHED: begin
                ctl.aclk = 1'b1;
                ctl.bg   = 1'b1;
                ctl.refb = 1'b1;
            end
            ST_BG_WAIT: begin
                ctl.aclk = 1'b1;
                ctl.bg   = 1'b1;
                ctl.refb = 1'b1;
                ctl.core = simul_q;
            end
            ST_CORE_WAIT: begin
                ctl.aclk = 1'b1;
                ctl.bg   = 1'b1;
                ctl.refb = 1'b1;
                ctl.core = 1'b1;
            end
            ST_READY: begin
                ctl.aclk = 1'b1;
                ctl.bg   = 1'b1;
                ctl.refb = 1'b1;
                ctl.core = 1'b1;
                ctl.rdy  = 1'b1;
            end
            default: begin
                ctl = '0;
            end
        endcase
    end

endmodule

// File: rtl/adc_pwr_gate.sv
// Passes conversion-start requests only while the converter is ready
// and no power-down is being requested in the same cycle.
module adc_pwr_gate (
    input  logic conv_req,
    input  logic ready,
    input  logic pwr_dn_req,
    output logic conv_start
);

    // Qualify the request.
    always_comb begin
        conv_start = conv_req && ready && !pwr_dn_req;
    end

endmodule

// File: rtl/adc_pwr_seq.sv
// Top of the converter power sequencer.
// Converts settling times into clock counts, then ties together the
// state machine, the shared timer, the output decoder and the start gate.
// Assumes a synchronous active-low reset and synchronous request inputs.
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 150_000_000,
    parameter int unsigned BG_SETTLE_US   = 5000,
    parameter int unsigned CORE_SETTLE_US = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_up_req,
    input  logic       pwr_dn_req,
    input  logic       simul_sel,
    input  logic [1:0] lp_sel,
    input  logic       conv_req,
    output logic       aclk_en,
    output logic       bg_en,
    output logic       ref_en,
    output logic       core_en,
    output logic       ready,
    output logic       conv_start
);

    localparam int unsigned BG_CYC   = settle_cycles(CLK_HZ, BG_SETTLE_US);
    localparam int unsigned CORE_CYC = settle_cycles(CLK_HZ, CORE_SETTLE_US);
    localparam int unsigned MAX_CYC  = (BG_CYC > CORE_CYC) ? BG_CYC : CORE_CYC;
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);

    pwr_state_e       state;
    logic             simul_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    pwr_out_t         ctl;

    adc_pwr_fsm #(
        .BG_CYC   (BG_CYC),
        .CORE_CYC (CORE_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up_req (pwr_up_req),
        .pwr_dn_req (pwr_dn_req),
        .simul_sel  (simul_sel),
        .lp_sel     (lp_sel),
        .tmr_last   (tmr_last),
        .state      (state),
        .simul_q    (simul_q),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    adc_pwr_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    adc_pwr_outdec u_dec (
        .state   (state),
        .simul_q (simul_q),
        .ctl     (ctl)
    );

    adc_pwr_gate u_gate (
        .conv_req   (conv_req),
        .ready      (ctl.rdy),
        .pwr_dn_req (pwr_dn_req),
        .conv_start (conv_start)
    );

    // Drive the output ports from the decoded controls.
    always_comb begin
        aclk_en = ctl.aclk;
        bg_en   = ctl.bg;
        ref_en  = ctl.refb;
        core_en = ctl.core;
        ready   = ctl.rdy;
    end

    // R4: the core is never powered without bandgap and reference
    p_core_needs_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (bg_en && ref_en));

    // R2: in staged mode the core rises only after the bandgap was up
    p_staged_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_en) && !simul_q) |-> $past(bg_en));

    // R6: the bandgap falls only after the core is already off
    p_bg_after_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bg_en) |-> !$past(core_en));

    // R6: power-down drops ready in the next cycle
    p_dn_clears_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_req |=> !ready);

    // R5: a start only passes with a settled, powered core
    p_start_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (ready && core_en && conv_req));

    // R10: analog blocks on implies converter clock on
    p_clk_with_analog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_en || core_en) |-> aclk_en);

endmodule

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;

    localparam int unsigned T_CLK_HZ = 1_000_000;
    localparam int unsigned T_BG_US  = 40;
    localparam int unsigned T_CORE_US = 12;
    localparam int N = int'((T_CLK_HZ / 1_000_000) * T_BG_US);
    localparam int M = int'((T_CLK_HZ / 1_000_000) * T_CORE_US);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_up_req = 1'b0;
    logic pwr_dn_req = 1'b0;
    logic simul_sel = 1'b0;
    logic [1:0] lp_sel = 2'b00;
    logic conv_req = 1'b0;
    logic aclk_en, bg_en, ref_en, core_en, ready, conv_start;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_pwr_seq #(
        .CLK_HZ         (T_CLK_HZ),
        .BG_SETTLE_US   (T_BG_US),
        .CORE_SETTLE_US (T_CORE_US)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up_req (pwr_up_req),
        .pwr_dn_req (pwr_dn_req),
        .simul_sel  (simul_sel),
        .lp_sel     (lp_sel),
        .conv_req   (conv_req),
        .aclk_en    (aclk_en),
        .bg_en      (bg_en),
        .ref_en     (ref_en),
        .core_en    (core_en),
        .ready      (ready),
        .conv_start (conv_start)
    );

    // Row: pulse inputs for one cycle, idle, then check with conv_req set.
    typedef struct packed {
        logic       up;
        logic       dn;
        logic       sim;
        logic [1:0] lp;
        logic [7:0] idle;
        logic       conv;
        logic [4:0] exp;   // {aclk, bg/ref, core, ready, start}
    } row_t;

    localparam int NROWS = 21;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 1'b0, 1'b0, 2'b00, 8'(N-2), 1'b1, 5'b11000}, // R2 bg only
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b0, 5'b11000}, // R2 core one early
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b0, 5'b11100}, // R2 core on time
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'(M-2), 1'b1, 5'b11100}, // R5 blocked
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b1, 5'b11111}, // R2 R5 ready
        '{1'b1, 1'b0, 1'b0, 2'b00, 8'd3,    1'b0, 5'b11110}, // R9 up ignored
        '{1'b0, 1'b1, 1'b0, 2'b01, 8'd0,    1'b0, 5'b11000}, // R6 shed
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b0, 5'b11000}, // R7 standby
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd5,    1'b1, 5'b11000}, // R7 standby holds
        '{1'b1, 1'b0, 1'b0, 2'b00, 8'd0,    1'b0, 5'b11100}, // R8 resume
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'(M-2), 1'b1, 5'b11100}, // R8 one early
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b1, 5'b11111}, // R8 ready
        '{1'b0, 1'b1, 1'b0, 2'b10, 8'd0,    1'b0, 5'b11000}, // R6 shed
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b0, 5'b10000}, // R7 deep
        '{1'b1, 1'b0, 1'b1, 2'b00, 8'd0,    1'b0, 5'b11100}, // R3 all on
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'(N-2), 1'b1, 5'b11100}, // R3 one early
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b1, 5'b11111}, // R3 ready
        '{1'b0, 1'b1, 1'b0, 2'b11, 8'd0,    1'b0, 5'b11000}, // R6 shed
        '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,    1'b0, 5'b00000}, // R7 R10 off
        '{1'b0, 1'b1, 1'b0, 2'b01, 8'd0,    1'b0, 5'b10000}, // R7 unsettled
        '{1'b0, 1'b1, 1'b0, 2'b00, 8'd0,    1'b0, 5'b00000}  // R7 off
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    // Compare {aclk, bg, ref, core, ready, start} against the expectation.
    task automatic check(input string req, input logic [4:0] exp);
        logic [5:0] act, want;
        act  = {aclk_en, bg_en, ref_en, core_en, ready, conv_start};
        want = {exp[4], exp[3], exp[3], exp[2], exp[1], exp[0]};
        n_checks++;
        if (act !== want) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", req, act, want);
        end
    endtask

    task automatic pulse(input logic up, input logic dn, input logic sim,
                         input logic [1:0] lp);
        pwr_up_req = up;
        pwr_dn_req = dn;
        simul_sel  = sim;
        lp_sel     = lp;
        tick();
        pwr_up_req = 1'b0;
        pwr_dn_req = 1'b0;
        simul_sel  = 1'b0;
        lp_sel     = 2'b00;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        idle(2);
        check("R1 in reset", 5'b00000);
        rst_n = 1'b1;
        tick();
        check("R1 after reset", 5'b00000);

        for (int r = 0; r < NROWS; r++) begin
            pulse(TBL[r].up, TBL[r].dn, TBL[r].sim, TBL[r].lp);
            idle(int'(TBL[r].idle));
            conv_req = TBL[r].conv;
            #1;
            check($sformatf("table row %0d", r), TBL[r].exp);
            conv_req = 1'b0;
        end

        // R9: repeated request mid-sequence does not restart the wait
        pulse(1'b1, 1'b0, 1'b0, 2'b00);      // past E0
        idle(4);                             // E4
        pulse(1'b1, 1'b0, 1'b1, 2'b00);      // E5, ignored
        idle(N - 6);                         // E(N-1)
        check("R9 no restart, core off", 5'b11000);
        tick();                              // E(N)
        check("R9 no restart, core on", 5'b11100);
        idle(M);
        check("R2 ready after retry", 5'b11110);

        // R5 and R9: dn with up and conv in the same cycle
        conv_req   = 1'b1;
        pwr_dn_req = 1'b1;
        pwr_up_req = 1'b1;
        lp_sel     = 2'b10;
        #1;
        check("R5 start blocked by dn", 5'b11110);
        tick();
        conv_req   = 1'b0;
        pwr_dn_req = 1'b0;
        pwr_up_req = 1'b0;
        lp_sel     = 2'b00;
        check("R9 dn wins over up", 5'b11000);
        tick();
        check("R7 deep after shed", 5'b10000);

        // R7: standby target during bandgap wait demotes to deep standby
        pulse(1'b1, 1'b0, 1'b0, 2'b00);
        idle(10);
        check("R2 mid bandgap wait", 5'b11000);
        pulse(1'b0, 1'b1, 1'b0, 2'b01);
        check("R7 unsettled standby is deep", 5'b10000);

        // R1: reset in mid-sequence
        pulse(1'b1, 1'b0, 1'b0, 2'b00);
        idle(5);
        rst_n = 1'b0;
        tick();
        check("R1 reset mid-sequence", 5'b00000);
        rst_n = 1'b1;
        tick();
        check("R1 stays off after reset", 5'b00000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule